// File: doc/BRIEF.md
# Memory Map Address Decoder

This block sits between an 8-bit processor's 16-bit address bus and the devices it reaches. The lower half of the address space selects a 32 KB ROM and the upper half selects a 32 KB RAM. A few addresses inside the ROM half are taken over by memory-mapped peripheral registers instead: a serial transmit port, a serial receive port and three sound-control registers. The ROM and RAM arrays are outside the block. It drives their selects, takes their read data back, and returns one read byte to the processor.

A write to the transmit address hands the byte to the serial side at once, with a one-cycle valid pulse and no busy handshake. A read of the receive address returns the last key code, or zero when no key is waiting. A nonzero result acknowledges the key so that it is not delivered twice. The sound registers hold a 14-bit frequency, a 4-bit volume and an enable bit, and all of them clear on reset. An optional boot overlay makes the first three ROM bytes read as a jump to the base of RAM. After reset the processor therefore continues in RAM even when the ROM is blank.

Top module: `mem_map_decoder`

## Requirements
- R1: An address with bit 15 clear selects ROM (`rom_sel`) and an address with bit 15 set selects RAM (`ram_sel`). `ram_we` is high only for a write to RAM.
- R2: The addresses 0x6000, 0x6001, 0x7FF0, 0x7FF1 and 0x7FF2 keep both `rom_sel` and `ram_sel` low. A write to any other address with bit 15 clear changes no output register.
- R3: A write to 0x6000 drives `tx_data` with the written byte on the next cycle. `tx_valid` is high for exactly that one cycle unless another write to 0x6000 follows.
- R4: A read of 0x6001 returns `key_code` on `cpu_rdata` in the same cycle. The value 0x00 means that no key is waiting.
- R5: A read of 0x6001 while `key_code` is nonzero raises `key_ack` for exactly the following cycle. A read while `key_code` is 0x00 raises no acknowledge.
- R6: A write to 0x7FF0 loads `freq_lo` with all 8 bits. A write to 0x7FF1 loads `freq_hi` with data bits 5:0, and bits 7:6 are dropped.
- R7: A write to 0x7FF2 loads `snd_vol` from data bits 3:0 and `snd_en` from data bit 7. Bits 6:4 are dropped.
- R8: While reset is asserted, `tx_data`, `tx_valid`, `key_ack`, `freq_lo`, `freq_hi`, `snd_vol` and `snd_en` are all zero.
- R9: With `cpu_rd` high, `cpu_rdata` follows `rom_q` for ROM addresses and `ram_q` for RAM addresses. It is 0x00 for the write-only addresses 0x6000 and 0x7FF0 to 0x7FF2. With `cpu_rd` low it is 0x00.
- R10: With the boot overlay enabled, reads of 0x0000, 0x0001 and 0x0002 return the jump opcode, 0x00 and 0x80, whatever `rom_q` holds. The target address is sent low byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data returned to the processor |
| rom_sel | output | 1 | ROM chip select |
| ram_sel | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| rom_q | input | 8 | ROM read data |
| ram_q | input | 8 | RAM read data |
| tx_data | output | 8 | Byte for the serial transmitter |
| tx_valid | output | 1 | One-cycle pulse when `tx_data` is new |
| key_code | input | 8 | Last received key, 0x00 when none |
| key_ack | output | 1 | One-cycle acknowledge of a delivered key |
| freq_lo | output | 8 | Sound frequency, low byte |
| freq_hi | output | 6 | Sound frequency, high bits |
| snd_vol | output | 4 | Sound volume |
| snd_en | output | 1 | Sound enable |

## Verification
The bench builds the block with the boot overlay switched on and the jump opcode set to 0x3C. This exposes both the overlaid reset vector and ROM pass-through on the byte just past it. The default 16-bit address and 8-bit data widths keep every peripheral address and the ROM/RAM boundary at the values named in the requirements. That makes it possible to probe the edges 0x5FFF, 0x7FF3, 0x7FFF and 0x8000 as well as back-to-back transmit writes and key reads with and without a pending key.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [2:0] {
    RG_ROM,
    RG_RAM,
    RG_TXD,
    RG_RXD,
    RG_FLO,
    RG_FHI,
    RG_SND
  } region_t;
endpackage

// File: rtl/mm_region_decode.sv
module mm_region_decode
  import mm_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] TX_ADDR  = 16'h6000,
  parameter logic [AW-1:0] RX_ADDR  = 16'h6001,
  parameter logic [AW-1:0] FLO_ADDR = 16'h7FF0,
  parameter logic [AW-1:0] FHI_ADDR = 16'h7FF1,
  parameter logic [AW-1:0] SND_ADDR = 16'h7FF2
) (
  input  logic [AW-1:0] addr,
  output region_t       region
);
  // Peripheral matches win over the ROM half they live in.
  always_comb begin
    if (addr == TX_ADDR)       region = RG_TXD;
    else if (addr == RX_ADDR)  region = RG_RXD;
    else if (addr == FLO_ADDR) region = RG_FLO;
    else if (addr == FHI_ADDR) region = RG_FHI;
    else if (addr == SND_ADDR) region = RG_SND;
    else if (addr[AW-1])       region = RG_RAM;
    else                       region = RG_ROM;
  end
endmodule

// File: rtl/mm_serial_port.sv
module mm_serial_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_tx,
  input  logic [DW-1:0] wdata,
  input  logic          rd_rx,
  input  logic [DW-1:0] key_code,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  output logic          key_ack
);
  logic [DW-1:0] tx_data_n;
  logic          tx_valid_n;
  logic          key_ack_n;
  logic          key_live;

  assign key_live = (key_code != '0);

  always_comb begin
    tx_data_n  = tx_data;
    tx_valid_n = wr_tx;
    key_ack_n  = rd_rx && key_live;
    if (wr_tx) tx_data_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
      key_ack  <= 1'b0;
    end else begin
      tx_data  <= tx_data_n;
      tx_valid <= tx_valid_n;
      key_ack  <= key_ack_n;
    end
  end

  assert_tx_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(wr_tx));
  assert_tx_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_tx) |-> $stable(tx_data));
  assert_ack_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_ack |-> $past(rd_rx && key_live));
endmodule

// File: rtl/mm_sound_regs.sv
module mm_sound_regs #(
  parameter int DW    = 8,
  parameter int FHI_W = 6,
  parameter int VOL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             wr_snd,
  input  logic [DW-1:0]    lo_in,
  input  logic [FHI_W-1:0] hi_in,
  input  logic [VOL_W-1:0] vol_in,
  input  logic             en_in,
  output logic [DW-1:0]    freq_lo,
  output logic [FHI_W-1:0] freq_hi,
  output logic [VOL_W-1:0] snd_vol,
  output logic             snd_en
);
  logic [DW-1:0]    freq_lo_n;
  logic [FHI_W-1:0] freq_hi_n;
  logic [VOL_W-1:0] snd_vol_n;
  logic             snd_en_n;

  always_comb begin
    freq_lo_n = freq_lo;
    freq_hi_n = freq_hi;
    snd_vol_n = snd_vol;
    snd_en_n  = snd_en;
    if (wr_lo) freq_lo_n = lo_in;
    if (wr_hi) freq_hi_n = hi_in;
    if (wr_snd) begin
      snd_vol_n = vol_in;
      snd_en_n  = en_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_lo <= '0;
      freq_hi <= '0;
      snd_vol <= '0;
      snd_en  <= 1'b0;
    end else begin
      freq_lo <= freq_lo_n;
      freq_hi <= freq_hi_n;
      snd_vol <= snd_vol_n;
      snd_en  <= snd_en_n;
    end
  end

  // R2: nothing but a strobe for these addresses moves the sound state.
  assert_snd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_lo || wr_hi || wr_snd) |-> $stable({freq_lo, freq_hi, snd_vol, snd_en}));
  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_lo, wr_hi, wr_snd}));
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mm_pkg::*;
#(
  parameter int AW           = 16,
  parameter int DW           = 8,
  parameter int FHI_W        = 6,
  parameter int VOL_W        = 4,
  parameter int EN_BIT       = 7,
  parameter bit BOOT_OVERLAY = 1'b1,
  parameter logic [DW-1:0] JMP_OP = 8'h3C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  output logic [DW-1:0]    cpu_rdata,
  output logic             rom_sel,
  output logic             ram_sel,
  output logic             ram_we,
  input  logic [DW-1:0]    rom_q,
  input  logic [DW-1:0]    ram_q,
  output logic [DW-1:0]    tx_data,
  output logic             tx_valid,
  input  logic [DW-1:0]    key_code,
  output logic             key_ack,
  output logic [DW-1:0]    freq_lo,
  output logic [FHI_W-1:0] freq_hi,
  output logic [VOL_W-1:0] snd_vol,
  output logic             snd_en
);
  localparam logic [AW-1:0] RAM_BASE = {1'b1, {(AW-1){1'b0}}};

  // Reset: asserted at once, released after two clock edges.
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  region_t region;
  mm_region_decode #(.AW(AW)) i_dec (
    .addr   (cpu_addr),
    .region (region)
  );

  logic wr_tx, rd_rx, wr_lo, wr_hi, wr_snd;
  always_comb begin
    rom_sel = (region == RG_ROM);
    ram_sel = (region == RG_RAM);
    ram_we  = ram_sel && cpu_wr;
    wr_tx   = cpu_wr && (region == RG_TXD);
    rd_rx   = cpu_rd && (region == RG_RXD);
    wr_lo   = cpu_wr && (region == RG_FLO);
    wr_hi   = cpu_wr && (region == RG_FHI);
    wr_snd  = cpu_wr && (region == RG_SND);
  end

  mm_serial_port #(.DW(DW)) i_ser (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_tx    (wr_tx),
    .wdata    (cpu_wdata),
    .rd_rx    (rd_rx),
    .key_code (key_code),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .key_ack  (key_ack)
  );

  mm_sound_regs #(.DW(DW), .FHI_W(FHI_W), .VOL_W(VOL_W)) i_snd (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_snd  (wr_snd),
    .lo_in   (cpu_wdata),
    .hi_in   (cpu_wdata[FHI_W-1:0]),
    .vol_in  (cpu_wdata[VOL_W-1:0]),
    .en_in   (cpu_wdata[EN_BIT]),
    .freq_lo (freq_lo),
    .freq_hi (freq_hi),
    .snd_vol (snd_vol),
    .snd_en  (snd_en)
  );

  // ROM view: the raw array, or a jump-to-RAM overlay on the first bytes.
  logic [DW-1:0] rom_view;
  generate
    if (BOOT_OVERLAY) begin : g_boot
      logic in_vec;
      assign in_vec = (cpu_addr[AW-1:2] == '0) && (cpu_addr[1:0] != 2'b11);
      always_comb begin
        rom_view = rom_q;
        if (in_vec) begin
          case (cpu_addr[1:0])
            2'b00:   rom_view = JMP_OP;
            2'b01:   rom_view = RAM_BASE[DW-1:0];
            default: rom_view = RAM_BASE[2*DW-1:DW];
          endcase
        end
      end
    end else begin : g_plain
      assign rom_view = rom_q;
    end
  endgenerate

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      case (region)
        RG_ROM:  cpu_rdata = rom_view;
        RG_RAM:  cpu_rdata = ram_q;
        RG_RXD:  cpu_rdata = key_code;
        default: cpu_rdata = '0;
      endcase
    end
  end

  assert_ram_above_half_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    ram_sel |-> cpu_addr[AW-1]);
  assert_periph_no_cs_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (region inside {RG_TXD, RG_RXD, RG_FLO, RG_FHI, RG_SND}) |-> (!rom_sel && !ram_sel));
  assert_ram_read_pass_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ram_sel && cpu_rd) |-> (cpu_rdata == ram_q));
  assert_rx_read_pass_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    rd_rx |-> (cpu_rdata == key_code));
endmodule

// File: tb/test_mem_map_decoder.sv
module test_mem_map_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata, rom_q, ram_q, key_code;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_rdata, tx_data, freq_lo;
  logic        rom_sel, ram_sel, ram_we, tx_valid, key_ack, snd_en;
  logic [5:0]  freq_hi;
  logic [3:0]  snd_vol;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  mem_map_decoder #(.BOOT_OVERLAY(1'b1), .JMP_OP(8'h3C)) i_mem_map_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .ram_we(ram_we),
    .rom_q(rom_q), .ram_q(ram_q), .tx_data(tx_data), .tx_valid(tx_valid),
    .key_code(key_code), .key_ack(key_ack), .freq_lo(freq_lo),
    .freq_hi(freq_hi), .snd_vol(snd_vol), .snd_en(snd_en)
  );

  // {rd, wr, addr, key, rom_q, ram_q, exp_rdata, exp_rom, exp_ram, exp_we}
  localparam int NV = 18;
  localparam logic [52:0] VEC [NV] = '{
    {1'b1,1'b0,16'h1234,8'h00,8'h5A,8'hA5,8'h5A,1'b1,1'b0,1'b0},
    {1'b1,1'b0,16'h7FFF,8'h00,8'h3C,8'hA5,8'h3C,1'b1,1'b0,1'b0},
    {1'b1,1'b0,16'h8000,8'h00,8'h5A,8'h77,8'h77,1'b0,1'b1,1'b0},
    {1'b1,1'b0,16'hFFFF,8'h00,8'h5A,8'hC4,8'hC4,1'b0,1'b1,1'b0},
    {1'b0,1'b1,16'h9000,8'h00,8'h5A,8'hC4,8'h00,1'b0,1'b1,1'b1},
    {1'b0,1'b1,16'h2000,8'h00,8'h5A,8'hC4,8'h00,1'b1,1'b0,1'b0},
    {1'b1,1'b0,16'h6000,8'h00,8'h5A,8'hC4,8'h00,1'b0,1'b0,1'b0},
    {1'b1,1'b0,16'h6001,8'h41,8'h5A,8'hC4,8'h41,1'b0,1'b0,1'b0},
    {1'b1,1'b0,16'h6001,8'h00,8'h5A,8'hC4,8'h00,1'b0,1'b0,1'b0},
    {1'b1,1'b0,16'h7FF0,8'h00,8'h5A,8'hC4,8'h00,1'b0,1'b0,1'b0},
    {1'b1,1'b0,16'h7FF2,8'h00,8'h5A,8'hC4,8'h00,1'b0,1'b0,1'b0},
    {1'b1,1'b0,16'h7FF3,8'h00,8'h99,8'hC4,8'h99,1'b1,1'b0,1'b0},
    {1'b1,1'b0,16'h5FFF,8'h00,8'h11,8'hC4,8'h11,1'b1,1'b0,1'b0},
    {1'b0,1'b0,16'h8000,8'h00,8'h11,8'h55,8'h00,1'b0,1'b1,1'b0},
    {1'b1,1'b0,16'h0000,8'h00,8'hFF,8'h55,8'h3C,1'b1,1'b0,1'b0},
    {1'b1,1'b0,16'h0001,8'h00,8'hFF,8'h55,8'h00,1'b1,1'b0,1'b0},
    {1'b1,1'b0,16'h0002,8'h00,8'hFF,8'h55,8'h80,1'b1,1'b0,1'b0},
    {1'b1,1'b0,16'h0003,8'h00,8'h12,8'h55,8'h12,1'b1,1'b0,1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = 16'h8000; cpu_wdata = 8'h00;
  endtask

  task automatic wr_at(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_rd = 1'b0; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic snd_all(input string tag, input logic [7:0] lo, input logic [5:0] hi,
                         input logic [3:0] vol, input logic en);
    chk(tag, {8'h00, freq_lo}, {8'h00, lo});
    chk(tag, {10'h0, freq_hi}, {10'h0, hi});
    chk(tag, {12'h0, snd_vol}, {12'h0, vol});
    chk(tag, {15'h0, snd_en}, {15'h0, en});
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle(); key_code = 8'h00; rom_q = 8'h00; ram_q = 8'h00;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 tx_valid", {15'h0, tx_valid}, 16'h0);
    chk("R8 key_ack", {15'h0, key_ack}, 16'h0);
    chk("R8 tx_data", {8'h0, tx_data}, 16'h0);
    snd_all("R8 sound", 8'h00, 6'h00, 4'h0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: R1, R2, R4, R9, R10
    for (int k = 0; k < NV; k++) begin
      logic [52:0] v;
      v = VEC[k];
      @(negedge clk);
      cpu_rd = v[52]; cpu_wr = v[51]; cpu_addr = v[50:35]; key_code = v[34:27];
      rom_q = v[26:19]; ram_q = v[18:11]; cpu_wdata = 8'h00;
      #1;
      chk($sformatf("R9 R10 R4 rdata vec%0d", k), {8'h0, cpu_rdata}, {8'h0, v[10:3]});
      chk($sformatf("R1 R2 rom_sel vec%0d", k), {15'h0, rom_sel}, {15'h0, v[2]});
      chk($sformatf("R1 R2 ram_sel vec%0d", k), {15'h0, ram_sel}, {15'h0, v[1]});
      chk($sformatf("R1 ram_we vec%0d", k), {15'h0, ram_we}, {15'h0, v[0]});
    end
    @(negedge clk); idle(); key_code = 8'h00;
    @(negedge clk);

    // R3 transmit pulse
    wr_at(16'h6000, 8'h48);
    @(negedge clk); idle();
    chk("R3 tx_valid pulse", {15'h0, tx_valid}, 16'h1);
    chk("R3 tx_data", {8'h0, tx_data}, 16'h0048);
    @(negedge clk);
    chk("R3 tx_valid drop", {15'h0, tx_valid}, 16'h0);
    chk("R3 tx_data hold", {8'h0, tx_data}, 16'h0048);

    // R3 back to back
    wr_at(16'h6000, 8'h11);
    wr_at(16'h6000, 8'h22);
    chk("R3 b2b first", {7'h0, tx_valid, tx_data}, 16'h0111);
    @(negedge clk); idle();
    chk("R3 b2b second", {7'h0, tx_valid, tx_data}, 16'h0122);
    @(negedge clk);
    chk("R3 b2b end", {15'h0, tx_valid}, 16'h0);

    // R6 R7 sound registers
    wr_at(16'h7FF0, 8'hAB);
    wr_at(16'h7FF1, 8'hFF);
    wr_at(16'h7FF2, 8'h8F);
    @(negedge clk); idle();
    snd_all("R6 R7 load", 8'hAB, 6'h3F, 4'hF, 1'b1);
    wr_at(16'h7FF2, 8'h70);
    wr_at(16'h7FF1, 8'hC5);
    @(negedge clk); idle();
    snd_all("R6 R7 masked", 8'hAB, 6'h05, 4'h0, 1'b0);

    // R2 writes to other ROM addresses are ignored
    wr_at(16'h7FF3, 8'h55);
    wr_at(16'h6002, 8'h66);
    wr_at(16'h0000, 8'h77);
    wr_at(16'h7FEF, 8'h88);
    @(negedge clk); idle();
    snd_all("R2 rom write ignored", 8'hAB, 6'h05, 4'h0, 1'b0);
    chk("R2 no tx", {7'h0, tx_valid, tx_data}, 16'h0022);

    // R5 key acknowledge
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = 16'h6001; key_code = 8'h41;
    #1;
    chk("R4 key read", {8'h0, cpu_rdata}, 16'h0041);
    chk("R5 no early ack", {15'h0, key_ack}, 16'h0);
    @(negedge clk); idle(); key_code = 8'h00;
    chk("R5 ack pulse", {15'h0, key_ack}, 16'h1);
    @(negedge clk);
    chk("R5 ack drop", {15'h0, key_ack}, 16'h0);
    cpu_rd = 1'b1; cpu_addr = 16'h6001; key_code = 8'h00;
    @(negedge clk); idle();
    chk("R5 no ack when empty", {15'h0, key_ack}, 16'h0);
    @(negedge clk);
    key_code = 8'h5B;
    @(negedge clk);
    chk("R5 no ack without read", {15'h0, key_ack}, 16'h0);

    // R8 reset mid-run clears registers
    rst_n = 1'b0;
    #2;
    snd_all("R8 async clear", 8'h00, 6'h00, 4'h0, 1'b0);
    chk("R8 tx clear", {7'h0, tx_valid, tx_data}, 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule